// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Mask Controller

This block holds the interrupt state of one DMA channel. The datapath sends one-cycle event pulses into it. The block latches each pulse into a sticky 12-bit status register. Software clears those bits by writing ones to them.

A mask register decides which pending bits can drive the single level-sensitive interrupt line. Software cannot write the mask directly. It changes the mask through two write-only ports: one unmasks the bits written as ones and the other masks them.

Two 8-bit counters count descriptor completions that requested an interrupt, one for the source side and one for the destination side. Each counter clears when it is read. When a counter wraps, it raises its own error bit.

The register interface is a simple 32-bit word-addressed port. A read returns data combinationally in the same cycle. Reads and writes take effect at the next rising clock edge. Accesses to offsets with no register behind them are flagged in the status register.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, the status register and both counters are zero, the mask reads 0xFFF and `irq_o` is low.
- R2: The status register sits at word offset 0. Its bits, from 11 down to 0, are:
  - bit 11: pause
  - bit 10: done
  - bit 9: write-data error
  - bit 8: read-data error
  - bit 7: destination-descriptor fetch error
  - bit 6: source-descriptor fetch error
  - bit 5: destination count error
  - bit 4: source count error
  - bit 3: byte-count overflow
  - bit 2: destination descriptor done
  - bit 1: source descriptor done
  - bit 0: bad register access
  
  A pulse on `hw_evt[i]` sets status bit i. Writing a 1 to a status bit clears it. Bits 31..12 of every read are zero.
- R3: The mask register at offset 1 is read-only, and a write to it changes nothing.
- R4: Writing to offset 2 clears each mask bit written as 1. Writing to offset 3 sets each mask bit written as 1. Reads of offsets 2 and 3 return zero.
- R5: `irq_o` is high exactly when some status bit is set while its mask bit is clear. It follows the status and mask registers one clock later.
- R6: A `src_dscr_done` pulse increments the source counter (offset 4) and sets status bit 1. A `dst_dscr_done` pulse increments the destination counter (offset 5) and sets status bit 2.
- R7: When a counter wraps from 255 to 0, its count error bit is set: bit 4 for the source counter and bit 5 for the destination counter.
- R8: A read of a counter returns its value and leaves it at zero. If a completion arrives in the same cycle as the read, the counter holds 1 afterwards and no wrap error is raised.
- R9: A read or write of offsets 6 and above sets status bit 0, and a read of such an offset returns zero.
- R10: When an event and a write-one-to-clear reach the same status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| hw_evt | input | 12 | Event pulses, one per status bit |
| src_dscr_done | input | 1 | Source descriptor completed with an interrupt request |
| dst_dscr_done | input | 1 | Destination descriptor completed with an interrupt request |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench goes after the following collisions:
- An event and a clear reaching the same status bit in the same cycle. A design that gave the clear priority would lose that event for good.
- A counter read in the same cycle as a completion. A design that got this wrong would report a count that is off by one, or raise a false wrap error.
- A counter running 256 completions without a read. This exposes a missing or misplaced count error bit.
- Writes to the read-only mask and to unmapped offsets. A careless decoder would corrupt the mask there, or fail to flag the bad access.

Random traffic through the enable and disable ports checks `irq_o` on every cycle. A design whose interrupt changed in the same cycle as the status or mask, or two cycles after it, would fail those checks.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int DATA_W = 32;
  localparam int STAT_W = 12;
  localparam int NREG   = 6;

  // status bit positions
  localparam int BIT_BADACC   = 0;
  localparam int BIT_SRC_DONE = 1;
  localparam int BIT_DST_DONE = 2;
  localparam int BIT_SRC_ACCT = 4;
  localparam int BIT_DST_ACCT = 5;

  // word offsets
  localparam int OFS_STAT = 0;
  localparam int OFS_MASK = 1;
  localparam int OFS_UNMASK = 2;
  localparam int OFS_DOMASK = 3;
  localparam int OFS_SCNT = 4;
  localparam int OFS_DCNT = 5;

  // sticky bits: a set beats a clear in the same cycle
  function automatic logic [STAT_W-1:0] sticky_next(input logic [STAT_W-1:0] cur,
                                                    input logic [STAT_W-1:0] clr,
                                                    input logic [STAT_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [STAT_W-1:0] mask_next(input logic [STAT_W-1:0] cur,
                                                  input logic [STAT_W-1:0] unm,
                                                  input logic [STAT_W-1:0] dom);
    return (cur & ~unm) | dom;
  endfunction
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NREG-1:0]   wr_hit,
  output logic [NREG-1:0]   rd_hit,
  output logic              bad_acc
);
  logic [NREG-1:0] hit;

  always_comb begin
    hit = '0;
    for (int i = 0; i < NREG; i++) begin
      hit[i] = bus_en && (bus_addr == ADDR_W'(i));
    end
  end

  assign wr_hit  = bus_we ? hit : '0;
  assign rd_hit  = bus_we ? '0 : hit;
  assign bad_acc = bus_en && !(|hit);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] clr,
  input  logic [STAT_W-1:0] set,
  output logic [STAT_W-1:0] stat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= sticky_next(stat_q, clr, set);
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] unmask,
  input  logic [STAT_W-1:0] domask,
  output logic [STAT_W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_next(mask_q, unmask, domask);
  end
endmodule

// File: rtl/irq_acct_counter.sv
module irq_acct_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  // a read empties the counter; a completion in the same cycle lands after it
  function automatic logic [CNT_W-1:0] acct_next(input logic [CNT_W-1:0] cur,
                                                 input logic up, input logic rd);
    if (rd) return up ? CNT_W'(1) : '0;
    return up ? cur + CNT_W'(1) : cur;
  endfunction

  assign wrap = inc && !rd_clr && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= acct_next(cnt_q, inc, rd_clr);
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [STAT_W-1:0] hw_evt,
  input  logic              src_dscr_done,
  input  logic              dst_dscr_done,
  output logic              irq_o
);
  localparam int NSIDE = 2;

  logic [NREG-1:0]   wr_hit, rd_hit;
  logic              bad_acc;
  logic [STAT_W-1:0] stat_q, mask_q, stat_set, stat_clr, unmask, domask;
  logic [NSIDE-1:0]  side_inc, side_rd, side_wrap;
  logic [CNT_W-1:0]  side_cnt [NSIDE];

  // named events for the checker
  logic             src_inc, dst_inc, src_rd, dst_rd, src_wrap, dst_wrap;
  logic [CNT_W-1:0] src_cnt, dst_cnt;

  irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_en  (bus_en),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit),
    .bad_acc (bad_acc)
  );

  assign side_inc = {dst_dscr_done, src_dscr_done};
  assign side_rd  = {rd_hit[OFS_DCNT], rd_hit[OFS_SCNT]};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    irq_acct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (side_inc[s]),
      .rd_clr(side_rd[s]),
      .cnt_q (side_cnt[s]),
      .wrap  (side_wrap[s])
    );
  end

  assign src_inc  = side_inc[0];
  assign dst_inc  = side_inc[1];
  assign src_rd   = side_rd[0];
  assign dst_rd   = side_rd[1];
  assign src_wrap = side_wrap[0];
  assign dst_wrap = side_wrap[1];
  assign src_cnt  = side_cnt[0];
  assign dst_cnt  = side_cnt[1];

  always_comb begin
    stat_set = hw_evt;
    stat_set[BIT_BADACC]   = stat_set[BIT_BADACC]   | bad_acc;
    stat_set[BIT_SRC_DONE] = stat_set[BIT_SRC_DONE] | src_inc;
    stat_set[BIT_DST_DONE] = stat_set[BIT_DST_DONE] | dst_inc;
    stat_set[BIT_SRC_ACCT] = stat_set[BIT_SRC_ACCT] | src_wrap;
    stat_set[BIT_DST_ACCT] = stat_set[BIT_DST_ACCT] | dst_wrap;
  end

  assign stat_clr = wr_hit[OFS_STAT]   ? bus_wdata[STAT_W-1:0] : '0;
  assign unmask   = wr_hit[OFS_UNMASK] ? bus_wdata[STAT_W-1:0] : '0;
  assign domask   = wr_hit[OFS_DOMASK] ? bus_wdata[STAT_W-1:0] : '0;

  irq_status_reg u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stat_clr),
    .set   (stat_set),
    .stat_q(stat_q)
  );

  irq_mask_reg u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .unmask(unmask),
    .domask(domask),
    .mask_q(mask_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(stat_q & ~mask_q);
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit[OFS_STAT]) bus_rdata = DATA_W'(stat_q);
    if (rd_hit[OFS_MASK]) bus_rdata = DATA_W'(mask_q);
    if (rd_hit[OFS_SCNT]) bus_rdata = DATA_W'(src_cnt);
    if (rd_hit[OFS_DCNT]) bus_rdata = DATA_W'(dst_cnt);
  end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_o,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] mask_q,
  input logic [STAT_W-1:0] stat_set,
  input logic [CNT_W-1:0]  src_cnt,
  input logic [CNT_W-1:0]  dst_cnt,
  input logic              src_inc,
  input logic              dst_inc,
  input logic              src_rd,
  input logic              dst_rd
);
  logic stat_wr, unm_wr, dom_wr, unmapped;
  assign stat_wr  = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_STAT));
  assign unm_wr   = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_UNMASK));
  assign dom_wr   = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_DOMASK));
  assign unmapped = bus_en && (bus_addr >= ADDR_W'(NREG));

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:STAT_W] == '0); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (stat_q & $past(bus_wdata[STAT_W-1:0] & ~stat_set)) == '0); // R2
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q & $past(stat_set)) == $past(stat_set)); // R10
  AST_MASK_RO: assert property (@(posedge clk) disable iff (!rst_n)
    !unm_wr && !dom_wr |=> $stable(mask_q)); // R3
  AST_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
    unm_wr |=> (mask_q & $past(bus_wdata[STAT_W-1:0])) == '0); // R4
  AST_DOMASK: assert property (@(posedge clk) disable iff (!rst_n)
    dom_wr |=> (mask_q & $past(bus_wdata[STAT_W-1:0])) == $past(bus_wdata[STAT_W-1:0])); // R4
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|(stat_q & ~mask_q))); // R5
  AST_SRC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    src_inc && !src_rd && (&src_cnt) |=> stat_q[BIT_SRC_ACCT]); // R7
  AST_DST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    dst_inc && !dst_rd && (&dst_cnt) |=> stat_q[BIT_DST_ACCT]); // R7
  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |=> src_cnt == CNT_W'($past(src_inc))); // R8
  AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |=> stat_q[BIT_BADACC]); // R9
  AST_BAD_RDZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped && !bus_we |-> bus_rdata == '0); // R9
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_o    (irq_o),
  .stat_q   (stat_q),
  .mask_q   (mask_q),
  .stat_set (stat_set),
  .src_cnt  (src_cnt),
  .dst_cnt  (dst_cnt),
  .src_inc  (src_inc),
  .dst_inc  (dst_inc),
  .src_rd   (src_rd),
  .dst_rd   (dst_rd)
);

// File: tb/tb_dma_irq_ctrl.sv
module tb_dma_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [11:0] hw_evt;
  logic        src_dscr_done, dst_dscr_done, irq_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model of the programmer-visible state
  logic [11:0] m_stat, m_mask;
  logic [7:0]  m_scnt, m_dcnt;
  logic        m_irq;

  always #10 clk = ~clk;

  dma_irq_ctrl #(.ADDR_W(4), .CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_evt(hw_evt), .src_dscr_done(src_dscr_done),
    .dst_dscr_done(dst_dscr_done), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_rdata(input logic [3:0] a);
    case (a)
      4'd0: return {20'd0, m_stat};
      4'd1: return {20'd0, m_mask};
      4'd4: return {24'd0, m_scnt};
      4'd5: return {24'd0, m_dcnt};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic we, input logic [3:0] a,
                      input logic [31:0] wd, input logic [11:0] evt,
                      input logic sd, input logic dd, input string tag);
    logic [11:0] set, clr;
    logic srd, drd, swrap, dwrap, bada, nirq;
    @(negedge clk);
    chk("R5 irq", {31'd0, irq_o}, {31'd0, m_irq});
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = wd;
    hw_evt = evt; src_dscr_done = sd; dst_dscr_done = dd;
    #2;
    if (en && !we) chk((tag == "") ? tag_of(a) : tag, bus_rdata, exp_rdata(a));
    bada  = en && (a > 4'd5);
    srd   = en && !we && (a == 4'd4);
    drd   = en && !we && (a == 4'd5);
    swrap = sd && !srd && (m_scnt == 8'hFF);
    dwrap = dd && !drd && (m_dcnt == 8'hFF);
    set   = evt | {6'd0, dwrap, swrap, 1'b0, dd, sd, bada};
    clr   = (en && we && a == 4'd0) ? wd[11:0] : 12'd0;
    nirq  = |(m_stat & ~m_mask);
    @(posedge clk);
    m_stat = (m_stat & ~clr) | set;
    if (en && we && a == 4'd2) m_mask = m_mask & ~wd[11:0];
    if (en && we && a == 4'd3) m_mask = m_mask | wd[11:0];
    m_scnt = srd ? {7'd0, sd} : m_scnt + {7'd0, sd};
    m_dcnt = drd ? {7'd0, dd} : m_dcnt + {7'd0, dd};
    m_irq  = nirq;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'd0, 12'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, 12'd0, 1'b0, 1'b0, "");
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    hw_evt = 0; src_dscr_done = 0; dst_dscr_done = 0;
    m_stat = 0; m_mask = 12'hFFF; m_scnt = 0; m_dcnt = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk("R1 irq", {31'd0, irq_o}, 32'd0);

    // R1 reset values
    rd(4'd1, "R1"); rd(4'd0, "R1"); rd(4'd4, "R1"); rd(4'd5, "R1");

    // R3 mask write ignored, R4 enable/disable ports
    wr(4'd1, 32'h0); rd(4'd1, "R3");
    wr(4'd2, 32'h00F); rd(4'd2, "R4"); rd(4'd1, "R4");
    wr(4'd3, 32'h003); rd(4'd3, "R4"); rd(4'd1, "R4");

    // R10 event beats clear on the same bit; R2 reserved bits
    step(1'b0, 1'b0, 4'd0, 0, 12'h20C, 1'b0, 1'b0, "");
    step(1'b1, 1'b1, 4'd0, 32'hFFFF_FFFF, 12'h200, 1'b0, 1'b0, "");
    rd(4'd0, "R10");
    wr(4'd0, 32'hFFF); rd(4'd0, "R2");

    // R6 counts and done bits
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 4'd0, 0, 12'd0, 1'b1, 1'b1, "");
    rd(4'd0, "R6"); rd(4'd4, "R6"); rd(4'd5, "R6");
    wr(4'd0, 32'hFFF);

    // R7 destination wrap after 256 completions
    for (int i = 0; i < 256; i++) step(1'b0, 1'b0, 4'd0, 0, 12'd0, 1'b0, 1'b1, "");
    rd(4'd0, "R7"); rd(4'd5, "R7");
    wr(4'd0, 32'hFFF);

    // R8 read at 255 together with a completion: no wrap, counter ends at 1
    for (int i = 0; i < 255; i++) step(1'b0, 1'b0, 4'd0, 0, 12'd0, 1'b1, 1'b0, "");
    step(1'b1, 1'b0, 4'd4, 0, 12'd0, 1'b1, 1'b0, "R8");
    rd(4'd4, "R8"); rd(4'd0, "R8");

    // R9 unmapped offsets
    rd(4'd9, "R9"); rd(4'd0, "R9");
    wr(4'd0, 32'hFFF); wr(4'd14, 32'hFFF); rd(4'd0, "R9");

    // R5 interrupt follows unmask then mask
    wr(4'd2, 32'hFFF);
    step(1'b0, 1'b0, 4'd0, 0, 12'h400, 1'b0, 1'b0, "");
    step(1'b0, 1'b0, 4'd0, 0, 12'd0, 1'b0, 1'b0, "");
    wr(4'd3, 32'hFFF);
    step(1'b0, 1'b0, 4'd0, 0, 12'd0, 1'b0, 1'b0, "");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] a;
      logic [11:0] ev;
      int r;
      r  = $urandom % 8;
      a  = (r < 6) ? 4'(r) : 4'($urandom % 16);
      ev = (($urandom % 4) == 0) ? 12'(1 << ($urandom % 12)) : 12'd0;
      step(1'($urandom % 3 != 0), 1'($urandom % 2), a, $urandom, ev,
           1'($urandom % 5 == 0), 1'($urandom % 5 == 0), "");
    end
    step(1'b0, 1'b0, 4'd0, 0, 12'd0, 1'b0, 1'b0, "");

    finished = 1;
    summary();
    $finish;
  end
endmodule